// File: doc/BRIEF.md
# Phase-Coded Sine Waveform Generator

This block turns a stream of six-phase code symbols into digital sine samples for a DAC. Each code element lasts one symbol of 64 output samples. During a symbol the generator emits one full cycle of a 64-point sine wave, and the wave starts at a phase set by that symbol's code. The phase steps are 60°. When the code changes between symbols, the result is a phase jump at the symbol boundary. Within a symbol the phase is continuous.

A free-running sample address counter walks a quarter-wave amplitude table. At every symbol boundary, that counter is preloaded with a starting address taken from a small phase table. A separate down-counting symbol timer marks the boundaries. Its all-ones terminal state, decoded through an inverted-AND test, triggers the preload.

The output is a valid/ready stream. When the consumer holds `out_ready` low while `out_valid` is high, both counters freeze and the presented sample is held unchanged until it is accepted. `code_in` is looked at only in the cycle that starts a new symbol.

Top module: `phase_code_wavegen`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_sym_start` are 0 on the next clock edge. After `rst_n` returns high, the first sample is a symbol start.
- R2: Code values 0, 1, 2, 3, 4 and 5 on `code_in` select starting table addresses 0, 11, 21, 32, 43 and 53. These are round(k·64/6), i.e. phases of 0°, 60°, 120°, 180°, 240° and 300°.
- R3: Code values 6 and 7 are invalid. They select starting address 0, the same as code 0.
- R4: A symbol is exactly 64 accepted samples. `out_sym_start` is high on the first sample of each symbol and low on the other 63.
- R5: Sample n (0..63) of a symbol with starting address o equals round(31·sin(2π·((o+n) mod 64)/64)). The phase therefore advances by one table step per accepted sample and wraps modulo 64.
- R6: Changes of `code_in` after a symbol's first sample have no effect on the samples of that symbol.
- R7: Back-pressure works as follows. While `out_valid` is 1 and `out_ready` is 0, `out_sample` and `out_sym_start` keep their values, `out_valid` stays 1 and no sample is skipped. A sample is transferred on a clock edge where `out_valid` and `out_ready` are both 1.
- R8: `out_sample` is two's complement and always lies within -31..+31 when valid.
- R9: A code presented at a symbol boundary takes effect on the first sample of the new symbol. That sample starts at the new code's starting address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low clear of both counters and the output stage |
| code_in | input | 3 | Phase code for the next symbol; sampled only at a symbol boundary |
| out_ready | input | 1 | Consumer accepts the presented sample |
| out_valid | output | 1 | A sample is presented |
| out_sample | output | SAMPLE_W (6) | Signed sine amplitude |
| out_sym_start | output | 1 | Presented sample is the first of a symbol |

## Verification
Two events can fall in the same cycle: a symbol-boundary reload and a back-pressure stall. If the stall is not respected at the boundary, the timer and the address counter could disagree about whether the reload happened. The bench provokes this with irregular `out_ready` patterns that land stalls on the last and first samples of symbols, and it changes `code_in` during those stalls. Every presented sample is then judged against an independent model, which advances its phase and symbol position only on accepted transfers.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  localparam int ADDR_W     = 6;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int QTR        = DEPTH / 4;
  localparam int CODE_W     = 3;
  localparam int NUM_PHASES = 6;
  localparam int MAG_W      = 5;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CODE_W-1:0] code_t;

  // Quarter-wave magnitude: round(31*sin(i*90deg/16)), i = 0..16
  function automatic logic [MAG_W-1:0] quarter_mag(input logic [4:0] i);
    logic [MAG_W-1:0] m;
    case (i)
      5'd0:  m = 5'd0;
      5'd1:  m = 5'd3;
      5'd2:  m = 5'd6;
      5'd3:  m = 5'd9;
      5'd4:  m = 5'd12;
      5'd5:  m = 5'd15;
      5'd6:  m = 5'd17;
      5'd7:  m = 5'd20;
      5'd8:  m = 5'd22;
      5'd9:  m = 5'd24;
      5'd10: m = 5'd26;
      5'd11: m = 5'd27;
      5'd12: m = 5'd29;
      5'd13: m = 5'd30;
      5'd14: m = 5'd30;
      default: m = 5'd31;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/pcw_phase_rom.sv
module pcw_phase_rom
  import pcw_pkg::*;
(
  input  code_t code,
  output addr_t start_addr
);
  addr_t table_q [NUM_PHASES];

  // Entry k = round(k*DEPTH/NUM_PHASES), computed at elaboration
  for (genvar k = 0; k < NUM_PHASES; k++) begin : g_ofs
    localparam int OFS = (2 * k * DEPTH + NUM_PHASES) / (2 * NUM_PHASES);
    assign table_q[k] = addr_t'(OFS);
  end

  always_comb begin
    if (int'(code) < NUM_PHASES) start_addr = table_q[code];
    else                         start_addr = '0;
  end
endmodule

// File: rtl/pcw_sine_rom.sv
module pcw_sine_rom
  import pcw_pkg::*;
#(
  parameter int SAMPLE_W = 6
) (
  input  addr_t                      addr,
  output logic signed [SAMPLE_W-1:0] sample
);
  localparam int IDX_W = ADDR_W - 2;

  logic [1:0]         quad;
  logic [IDX_W-1:0]   idx;
  logic [4:0]         qi;
  logic [MAG_W-1:0]   mag;
  logic signed [SAMPLE_W-1:0] pos;

  assign quad = addr[ADDR_W-1 -: 2];
  assign idx  = addr[IDX_W-1:0];

  always_comb begin
    if (quad[0]) qi = 5'(QTR) - 5'(idx);
    else         qi = 5'(idx);
    mag    = quarter_mag(qi);
    pos    = SAMPLE_W'(mag);
    sample = quad[1] ? -pos : pos;
  end
endmodule

// File: rtl/pcw_symbol_timer.sv
module pcw_symbol_timer
  import pcw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic boundary
);
  addr_t cnt;
  logic  tc_n;

  // inverted-AND terminal decode: low only in the all-ones state
  assign tc_n     = ~(&cnt);
  assign boundary = ~tc_n;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '1;
    else if (adv) cnt <= cnt - 1'b1;
  end

  AST_TC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt == '0) |=> boundary); // R4
endmodule

// File: rtl/pcw_addr_counter.sv
module pcw_addr_counter
  import pcw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  logic  load,
  input  addr_t start_addr,
  output addr_t cur_addr
);
  addr_t addr_q;

  assign cur_addr = load ? start_addr : addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   addr_q <= '0;
    else if (adv) addr_q <= cur_addr + 1'b1;
  end
endmodule

// File: rtl/phase_code_wavegen.sv
module phase_code_wavegen
  import pcw_pkg::*;
#(
  parameter int SAMPLE_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CODE_W-1:0]         code_in,
  input  logic                      out_ready,
  output logic                      out_valid,
  output logic signed [SAMPLE_W-1:0] out_sample,
  output logic                      out_sym_start
);
  logic  adv;
  logic  boundary;
  addr_t start_addr;
  addr_t cur_addr;
  logic signed [SAMPLE_W-1:0] rom_sample;

  assign adv = !out_valid || out_ready;

  pcw_symbol_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .boundary (boundary)
  );

  pcw_phase_rom u_phase (
    .code       (code_in),
    .start_addr (start_addr)
  );

  pcw_addr_counter u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (adv),
    .load       (boundary),
    .start_addr (start_addr),
    .cur_addr   (cur_addr)
  );

  pcw_sine_rom #(.SAMPLE_W(SAMPLE_W)) u_sine (
    .addr   (cur_addr),
    .sample (rom_sample)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_sample    <= '0;
      out_sym_start <= 1'b0;
    end else if (adv) begin
      out_valid     <= 1'b1;
      out_sample    <= rom_sample;
      out_sym_start <= boundary;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample) && $stable(out_sym_start))); // R7

  AST_AMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sample <= 31 && out_sample >= -31)); // R8

  AST_VALID_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid); // R1
endmodule

// File: tb/phase_code_wavegen_test.sv
`timescale 1ns/1ps
module phase_code_wavegen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] code_in = 3'd0;
  logic       out_ready = 1'b0;
  logic       out_valid;
  logic signed [5:0] out_sample;
  logic       out_sym_start;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model state
  bit m_valid = 0;
  bit m_start = 0;
  int m_pos = 0;
  int m_off = 0;
  int m_sample = 0;

  always #2.5 clk = ~clk;

  phase_code_wavegen uut (
    .clk(clk), .rst_n(rst_n), .code_in(code_in), .out_ready(out_ready),
    .out_valid(out_valid), .out_sample(out_sample), .out_sym_start(out_sym_start)
  );

  function automatic int exp_offset(input int code);
    if (code > 5) return 0;
    return $rtoi(code * 64.0 / 6.0 + 0.5);
  endfunction

  function automatic int exp_sine(input int a);
    real x;
    x = 31.0 * $sin(2.0 * 3.14159265358979 * a / 64.0);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive at negedge, observe at the next negedge
  task automatic step(input int code, input bit rdy, input string tag);
    bit adv;
    code_in   = 3'(code);
    out_ready = rdy;
    adv = !m_valid || rdy;
    if (adv) begin
      if (m_pos == 0) begin
        m_off = exp_offset(code);
        m_start = 1;
      end else m_start = 0;
      m_sample = exp_sine((m_off + m_pos) % 64);
      m_pos = (m_pos + 1) % 64;
      m_valid = 1;
    end
    @(negedge clk);
    check(out_valid == m_valid, {tag, " valid"}, out_valid, m_valid);
    check(out_sym_start == m_start, {tag, " sym_start"}, out_sym_start, m_start);
    check(int'(out_sample) == m_sample, {tag, " sample"}, out_sample, m_sample);
    if (out_valid)
      check(out_sample <= 31 && out_sample >= -31, "R8 range", out_sample, 31);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    check(out_sym_start == 1'b0, "R1 start in reset", out_sym_start, 0);
    m_valid = 0; m_pos = 0;
    rst_n = 1'b1;
    step(0, 1, "R1 first");
    check(out_sym_start == 1'b1, "R1 first is start", out_sym_start, 1);
  endtask

  task automatic t_all_codes;
    // finish the symbol begun by t_reset, then one symbol per code
    for (int i = 1; i < 64; i++) step(0, 1, "R5 code0");
    for (int c = 0; c < 8; c++) begin
      int starts = 0;
      for (int i = 0; i < 64; i++) begin
        step(c, 1, (c > 5) ? "R3 invalid code" : "R2 R5 code");
        if (out_sym_start) starts++;
      end
      check(starts == 1, "R4 one start per 64", starts, 1);
    end
  endtask

  task automatic t_mid_change;
    for (int i = 0; i < 30; i++) step(2, 1, "R5 before change");
    for (int i = 30; i < 64; i++) step(5, 1, "R6 mid change ignored");
    step(4, 1, "R9 new phase at boundary");
    check(int'(out_sample) == exp_sine(43), "R9 first sample", out_sample, exp_sine(43));
    for (int i = 1; i < 64; i++) step((i % 2) ? 1 : 7, 1, "R6 toggling code");
  endtask

  task automatic t_backpressure;
    for (int i = 0; i < 400; i++) begin
      bit r;
      r = (i % 3 != 0) && (i % 7 >= 2);
      step(i % 8, r, "R7 stall");
    end
  endtask

  initial begin
    t_reset();
    t_all_codes();
    t_mid_change();
    t_backpressure();
    t_reset();
    t_backpressure();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule